// File: doc/BRIEF.md
# Signed Multiply-Accumulate Long Unit

This block multiplies two signed 32-bit operands and adds the product to a signed 64-bit accumulator. The accumulator arrives as a high word and a low word. The 64-bit sum returns as a high word and a low word. The block can also recompute the negative and zero condition flags from the sum, and it always passes carry and overflow through. A start pulse launches one operation. A predicate input says whether the operation takes effect at all. When the predicate is false, the unit returns the accumulator and the incoming flags unchanged. A one-cycle done pulse marks the cycle in which the outputs first carry the new values.

The multiply is iterative. Each cycle retires `BPS` multiplier bits, so a predicated operation takes `OP_W/BPS` working cycles; with the defaults that is 8 cycles. While the unit is working it ignores further start pulses. The outputs keep their values between done pulses, so a consumer may sample them at any time after done. Decoding, register-file access and evaluation of the condition code are done outside the block.

Top module: `smac_long_unit`

## Requirements
- R1: When `cond_i` is high at the accepting edge, the 64-bit result equals signed(`op_a_i`) times signed(`op_b_i`) plus signed {`acc_hi_i`,`acc_lo_i`}, taken modulo 2^64. This covers most-negative operands and accumulator wrap-around.
- R2: The accumulator is formed as {`acc_hi_i`,`acc_lo_i`}. Result bits 63:32 appear on `res_hi_o` and bits 31:0 appear on `res_lo_o`.
- R3: When `cond_i` is low at the accepting edge, `done_o` is high in the next cycle. In that cycle {`res_hi_o`,`res_lo_o`} equals the accumulator and `flags_o` equals `flags_i`, regardless of `setf_i`.
- R4: When `cond_i` and `setf_i` are both high, the negative flag `flags_o[3]` equals bit 63 of the result.
- R5: When `cond_i` and `setf_i` are both high, the zero flag `flags_o[2]` is 1 exactly when all 64 result bits are zero.
- R6: The carry flag `flags_o[1]` and the overflow flag `flags_o[0]` always equal the values captured from `flags_i[1:0]` at the accepting edge.
- R7: When `setf_i` is low, `flags_o` equals the captured `flags_i` in all four bits.
- R8: A start is accepted at a clock edge where `start_i` is high and the unit is idle. With `cond_i` high, `done_o` is high for exactly one cycle, `OP_W/BPS` cycles after the cycle that follows the accepting edge. With the defaults, take the start cycle as cycle 0; done then appears in cycle 9.
- R9: A `start_i` pulse while an operation is in progress is ignored. The running operation finishes on time with its own operands, and no extra done pulse follows.
- R10: `res_hi_o`, `res_lo_o` and `flags_o` change only in a cycle where `done_o` is high, and otherwise hold their values.
- R11: Synchronous active-high `rst` returns the unit to idle and clears `done_o`, the result words and the flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, taken when idle |
| cond_i | input | 1 | Predicate; low suppresses the whole operation |
| setf_i | input | 1 | Recompute N and Z from the result |
| op_a_i | input | 32 | Signed multiplicand |
| op_b_i | input | 32 | Signed multiplier |
| acc_hi_i | input | 32 | Accumulator bits 63:32 |
| acc_lo_i | input | 32 | Accumulator bits 31:0 |
| flags_i | input | 4 | Incoming flags {N,Z,C,V} |
| done_o | output | 1 | One-cycle completion pulse |
| res_hi_o | output | 32 | Result bits 63:32 |
| res_lo_o | output | 32 | Result bits 31:0 |
| flags_o | output | 4 | Outgoing flags {N,Z,C,V} |

## Verification
The following are checked on every cycle:
- the done timing, derived from an independent latency counter that also captures each operation's inputs;
- the arithmetic against a full 64-bit reference product;
- the suppression path;
- each flag rule;
- the holding of the outputs between done pulses.

Some behaviours need scenarios from the bench. These are the extreme operand pairs, wrap-around of the 64-bit sum, a zero result that sets the zero flag, and a start pulse placed in the middle of an operation. The reset values also need the bench, since every clocked check is disabled while reset is high.

// File: rtl/smac_pkg.sv
package smac_pkg;

    // Bit positions of the condition flags inside the 4-bit flag vectors.
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/smac_step.sv
// One iteration of the shift-add multiplier: it adds BPS weighted copies of the
// multiplicand into the running sum. On the final iteration the top multiplier
// bit carries negative weight, as two's complement requires.
module smac_step #(
    parameter int ACC_W = 64,
    parameter int BPS   = 4
) (
    input  logic [ACC_W-1:0] sum_i,
    input  logic [ACC_W-1:0] mcand_i,
    input  logic [BPS-1:0]   bits_i,
    input  logic             last_i,
    output logic [ACC_W-1:0] sum_o
);

    logic [ACC_W-1:0] pp [BPS];

    for (genvar j = 0; j < BPS; j++) begin : g_pp
        assign pp[j] = bits_i[j] ? (mcand_i << j) : '0;
    end

    always_comb begin
        logic [ACC_W-1:0] run;
        run = sum_i;
        for (int j = 0; j < BPS; j++) begin
            if (last_i && (j == BPS - 1)) begin
                run = run - pp[j];
            end else begin
                run = run + pp[j];
            end
        end
        sum_o = run;
    end

endmodule

// File: rtl/smac_flags.sv
// Flag update: N and Z are recomputed when requested; C and V are carried through.
module smac_flags #(
    parameter int ACC_W = 64
) (
    input  logic [ACC_W-1:0] res_i,
    input  logic             setf_i,
    input  logic [3:0]       fin_i,
    output logic [3:0]       fout_o
);

    import smac_pkg::*;

    always_comb begin
        fout_o = fin_i;
        if (setf_i) begin
            fout_o[FLAG_N] = res_i[ACC_W-1];
            fout_o[FLAG_Z] = ~|res_i;
        end
    end

endmodule

// File: rtl/smac_long_unit.sv
module smac_long_unit #(
    parameter int OP_W = 32,
    parameter int BPS  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            cond_i,
    input  logic            setf_i,
    input  logic [OP_W-1:0] op_a_i,
    input  logic [OP_W-1:0] op_b_i,
    input  logic [OP_W-1:0] acc_hi_i,
    input  logic [OP_W-1:0] acc_lo_i,
    input  logic [3:0]      flags_i,
    output logic            done_o,
    output logic [OP_W-1:0] res_hi_o,
    output logic [OP_W-1:0] res_lo_o,
    output logic [3:0]      flags_o
);

    import smac_pkg::*;

    localparam int ACC_W = 2 * OP_W;
    localparam int STEPS = OP_W / BPS;
    localparam int CNT_W = $clog2(STEPS) + 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  step;
        logic [ACC_W-1:0]  sum;
        logic [ACC_W-1:0]  mcand;
        logic [OP_W-1:0]   mplier;
        logic              setf;
        logic [3:0]        fin;
        logic [OP_W-1:0]   hi;
        logic [OP_W-1:0]   lo;
        logic [3:0]        fl;
        logic              done;
    } st_t;

    st_t st_d, st_q;

    logic [ACC_W-1:0] step_sum;
    logic [3:0]       step_flags;
    logic             last_step;

    assign last_step = (st_q.step == LAST_STEP);

    smac_step #(
        .ACC_W (ACC_W),
        .BPS   (BPS)
    ) u_step (
        .sum_i   (st_q.sum),
        .mcand_i (st_q.mcand),
        .bits_i  (st_q.mplier[BPS-1:0]),
        .last_i  (last_step),
        .sum_o   (step_sum)
    );

    smac_flags #(
        .ACC_W (ACC_W)
    ) u_flags (
        .res_i  (step_sum),
        .setf_i (st_q.setf),
        .fin_i  (st_q.fin),
        .fout_o (step_flags)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (cond_i) begin
                        st_d.phase  = PH_RUN;
                        st_d.step   = '0;
                        st_d.sum    = {acc_hi_i, acc_lo_i};
                        st_d.mcand  = {{OP_W{op_a_i[OP_W-1]}}, op_a_i};
                        st_d.mplier = op_b_i;
                        st_d.setf   = setf_i;
                        st_d.fin    = flags_i;
                    end else begin
                        st_d.hi   = acc_hi_i;
                        st_d.lo   = acc_lo_i;
                        st_d.fl   = flags_i;
                        st_d.done = 1'b1;
                    end
                end
            end
            PH_RUN: begin
                st_d.sum    = step_sum;
                st_d.mcand  = st_q.mcand << BPS;
                st_d.mplier = st_q.mplier >> BPS;
                st_d.step   = st_q.step + 1'b1;
                if (last_step) begin
                    st_d.phase = PH_IDLE;
                    st_d.hi    = step_sum[ACC_W-1:OP_W];
                    st_d.lo    = step_sum[OP_W-1:0];
                    st_d.fl    = step_flags;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign res_hi_o = st_q.hi;
    assign res_lo_o = st_q.lo;
    assign flags_o  = st_q.fl;

endmodule

// File: rtl/smac_long_unit_chk.sv
module smac_long_unit_chk #(
    parameter int OP_W = 32,
    parameter int BPS  = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            cond_i,
    input logic            setf_i,
    input logic [OP_W-1:0] op_a_i,
    input logic [OP_W-1:0] op_b_i,
    input logic [OP_W-1:0] acc_hi_i,
    input logic [OP_W-1:0] acc_lo_i,
    input logic [3:0]      flags_i,
    input logic            done_o,
    input logic [OP_W-1:0] res_hi_o,
    input logic [OP_W-1:0] res_lo_o,
    input logic [3:0]      flags_o
);

    localparam int ACC_W = 2 * OP_W;
    localparam int STEPS = OP_W / BPS;
    localparam int CNT_W = $clog2(STEPS) + 1;

    logic [CNT_W-1:0] wait_q;
    logic             exp_done_q;
    logic             accept;
    logic [OP_W-1:0]  a_cap, b_cap;
    logic [ACC_W-1:0] acc_cap;
    logic [3:0]       fl_cap;
    logic             cond_cap, setf_cap;
    logic [ACC_W-1:0] ref_sum;
    logic [ACC_W-1:0] res_w;

    assign accept = start_i && (wait_q == '0);
    assign res_w  = {res_hi_o, res_lo_o};
    assign ref_sum = $signed({{OP_W{a_cap[OP_W-1]}}, a_cap})
                   * $signed({{OP_W{b_cap[OP_W-1]}}, b_cap}) + acc_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q     <= '0;
            exp_done_q <= 1'b0;
            a_cap      <= '0;
            b_cap      <= '0;
            acc_cap    <= '0;
            fl_cap     <= '0;
            cond_cap   <= 1'b0;
            setf_cap   <= 1'b0;
        end else begin
            exp_done_q <= (accept && !cond_i) || (wait_q == CNT_W'(1));
            if (accept) begin
                wait_q   <= cond_i ? CNT_W'(STEPS) : '0;
                a_cap    <= op_a_i;
                b_cap    <= op_b_i;
                acc_cap  <= {acc_hi_i, acc_lo_i};
                fl_cap   <= flags_i;
                cond_cap <= cond_i;
                setf_cap <= setf_i;
            end else if (wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    assert_done_timing_R8: assert property (@(posedge clk) disable iff (rst)
        done_o == exp_done_q);

    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && cond_cap) |-> (res_w == ref_sum));

    assert_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !cond_cap) |-> (res_w == acc_cap && flags_o == fl_cap));

    assert_neg_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (done_o && cond_cap && setf_cap) |-> (flags_o[3] == res_hi_o[OP_W-1]));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && cond_cap && setf_cap) |-> (flags_o[2] == (res_w == '0)));

    assert_cv_pass_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flags_o[1:0] == fl_cap[1:0]));

    assert_flags_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !setf_cap) |-> (flags_o == fl_cap));

    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(flags_o)));

endmodule

bind smac_long_unit smac_long_unit_chk #(
    .OP_W (OP_W),
    .BPS  (BPS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cond_i   (cond_i),
    .setf_i   (setf_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .acc_hi_i (acc_hi_i),
    .acc_lo_i (acc_lo_i),
    .flags_i  (flags_i),
    .done_o   (done_o),
    .res_hi_o (res_hi_o),
    .res_lo_o (res_lo_o),
    .flags_o  (flags_o)
);

// File: tb/sim_smac_long_unit.sv
module sim_smac_long_unit;

    localparam int STEPS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        cond_i = 1'b0;
    logic        setf_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [31:0] acc_hi_i = '0;
    logic [31:0] acc_lo_i = '0;
    logic [3:0]  flags_i = '0;
    logic        done_o;
    logic [31:0] res_hi_o;
    logic [31:0] res_lo_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    smac_long_unit u0 (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cond_i   (cond_i),
        .setf_i   (setf_i),
        .op_a_i   (op_a_i),
        .op_b_i   (op_b_i),
        .acc_hi_i (acc_hi_i),
        .acc_lo_i (acc_lo_i),
        .flags_i  (flags_i),
        .done_o   (done_o),
        .res_hi_o (res_hi_o),
        .res_lo_o (res_lo_o),
        .flags_o  (flags_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mac(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] hi, input logic [31:0] lo);
        logic signed [63:0] sa, sb, sacc;
        sa   = $signed(a);
        sb   = $signed(b);
        sacc = $signed({hi, lo});
        return 64'(sa * sb + sacc);
    endfunction

    // Runs one operation. Expected latency, result and flags come from the requirements.
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] hi, input logic [31:0] lo,
                          input logic cond, input logic setf, input logic [3:0] fl);
        int n;
        logic [63:0] exp_res;
        logic [3:0]  exp_fl;
        @(negedge clk);
        op_a_i = a; op_b_i = b; acc_hi_i = hi; acc_lo_i = lo;
        cond_i = cond; setf_i = setf; flags_i = fl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (cond) begin
            exp_res = ref_mac(a, b, hi, lo);
            chk({tag, " R8 latency"}, 64'(n), 64'(STEPS + 1));
            chk({tag, " R1 R2 result"}, {res_hi_o, res_lo_o}, exp_res);
        end else begin
            exp_res = {hi, lo};
            chk({tag, " R3 latency"}, 64'(n), 64'd1);
            chk({tag, " R3 result"}, {res_hi_o, res_lo_o}, exp_res);
        end
        exp_fl = fl;
        if (cond && setf) begin
            exp_fl[3] = exp_res[63];
            exp_fl[2] = (exp_res == 64'd0);
        end
        chk({tag, " R4 R5 R6 R7 flags"}, 64'(flags_o), 64'(exp_fl));
        @(negedge clk);
        chk({tag, " R8 single pulse"}, 64'(done_o), 64'd0);
        chk({tag, " R10 hold"}, {res_hi_o, res_lo_o}, exp_res);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 done after reset", 64'(done_o), 64'd0);
        chk("R11 result after reset", {res_hi_o, res_lo_o}, 64'd0);
        chk("R11 flags after reset", 64'(flags_o), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        run_op("basic", 32'd7, 32'd9, 32'd0, 32'd100, 1'b1, 1'b1, 4'b0000);
        run_op("neg product", 32'hFFFF_FFFD, 32'd5, 32'd0, 32'd4, 1'b1, 1'b1, 4'b0011);
        run_op("carry into hi", 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0000);
    endtask

    task automatic t_extremes();
        run_op("min*min", 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 1'b1, 4'b0000);
        run_op("min*-1", 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b1, 1'b1, 4'b0000);
        run_op("max*min", 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b1100);
    endtask

    task automatic t_wrap();
        run_op("wrap up", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0000);
        run_op("wrap down", 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 4'b0000);
    endtask

    task automatic t_zero();
        run_op("zero result", 32'd6, 32'hFFFF_FFFE, 32'd0, 32'd12, 1'b1, 1'b1, 4'b0011);
        run_op("zero operands", 32'd0, 32'd0, 32'd0, 32'd0, 1'b1, 1'b1, 4'b1010);
    endtask

    task automatic t_noflags();
        run_op("setf low", 32'd6, 32'hFFFF_FFFE, 32'd0, 32'd12, 1'b1, 1'b0, 4'b1001);
        run_op("setf low neg", 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd0, 1'b1, 1'b0, 4'b0110);
    endtask

    task automatic t_cond_false();
        run_op("cond low setf", 32'd3, 32'd4, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1, 4'b0101);
        run_op("cond low plain", 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0, 1'b0, 1'b0, 4'b1111);
    endtask

    task automatic t_busy_start();
        int n;
        int extra;
        logic [63:0] exp_res;
        exp_res = ref_mac(32'd1000, 32'd3000, 32'd0, 32'd5);
        @(negedge clk);
        op_a_i = 32'd1000; op_b_i = 32'd3000; acc_hi_i = 32'd0; acc_lo_i = 32'd5;
        cond_i = 1'b1; setf_i = 1'b1; flags_i = 4'b0000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        repeat (2) begin @(negedge clk); n++; end
        op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h1234_5678; cond_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        n++;
        start_i = 1'b0;
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R9 busy latency", 64'(n), 64'(STEPS + 1));
        chk("R9 busy result", {res_hi_o, res_lo_o}, exp_res);
        extra = 0;
        repeat (12) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R9 no extra done", 64'(extra), 64'd0);
        chk("R10 hold after idle", {res_hi_o, res_lo_o}, exp_res);
    endtask

    task automatic t_sweep();
        logic [31:0] x;
        x = 32'h1357_9BDF;
        for (int i = 0; i < 6; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            run_op("sweep", x, x ^ 32'hA5A5_5A5A, {x[15:0], x[31:16]}, ~x, 1'b1, i[0], 4'(i));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_extremes();
        t_wrap();
        t_zero();
        t_noflags();
        t_cond_false();
        t_busy_start();
        t_sweep();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule